// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous burst SRAM. It accepts a new read or write command on every clock cycle, in any mix, and never needs an idle cycle when the bus switches direction. Address, command, chip enables and byte-write selects are captured on the rising clock edge. Read data leaves through an output register. Write data follows two cycles behind its command, so it occupies the same bus slot that a read issued on the same edge would use.

Accepted writes are not committed to the array straight away. They wait in a short shift registry of pending entries. Every read merges, byte by byte, the array word with all pending entries and with the write whose data arrives on the same edge. The newest write wins for each byte. A two-bit burst sequencer can continue the previous command at the next address, in linear or interleaved order. An active-low clock enable freezes the entire pipeline.

Top module: `zt_pipe_sram`

## Requirements
- R1: A read loaded on edge n puts its word into the output register on edge n+1, so the word is valid for sampling on edge n+2. When `oeN` is low, `qDrv` is high for that cycle.
- R2: For a write loaded on edge n, the data on `dIn` is taken on edge n+2. `dIn` is ignored on every other edge.
- R3: While `cenN` is high, no input is sampled. The pipeline, pending writes, `qOut` and `qDrv` all keep their values.
- R4: Bit i of `bwN` is active low and guards lane i, which is bits i*LANE_W to i*LANE_W+LANE_W-1. `weN` low on a load means write. Lanes whose select is high keep their old contents.
- R5: A load selects the device only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Any other combination is a deselect: no array access, and `qDrv` is low in the matching data slot.
- R6: `qDrv` is low during the data slot of a write, of a deselect, and of a stall that follows them. `qDrv` equals the output-register valid flag ANDed with `oeN` low, and follows `oeN` without waiting for a clock.
- R7: A read returns every earlier write in command order. This includes writes still pending and the write issued one cycle before it, whose data arrives on the same edge. Each byte comes from the newest write that covered it.
- R8: On an edge with `advLd`=0, the command type and selection of the last load are repeated at the next burst address. `ce1N`, `ce2`, `ce3N` and `weN` are ignored, but `bwN` is sampled again for each beat.
- R9: Linear order: beat c uses low address bits (base + c) mod 4. The upper address bits stay at the loaded value.
- R10: Interleaved order: beat c uses low bits base XOR c. `burstIlv`=1 selects interleaved order and is sampled only on a load.
- R11: While `rstN` is low, `qDrv` is 0 and the pipeline empties. The array contents survive a reset.
- R12: Any sequence of reads and writes, one per cycle, runs with no inserted idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| cenN | input | 1 | Active-low clock enable; high stalls everything |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | Active-low write command on a load |
| advLd | input | 1 | 1 loads a new command, 0 advances the burst |
| burstIlv | input | 1 | Burst order on load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| bwN | input | LANES | Active-low byte-lane write selects |
| dIn | input | LANES*LANE_W | Write data, two cycles after the command |
| oeN | input | 1 | Active-low output enable, combinational |
| qOut | output | LANES*LANE_W | Registered read data |
| qDrv | output | 1 | High when the data bus is driven by the block |

## Verification
The hardest situation to reach from the ports is a read whose word is split across several sources at once. Some bytes come from the array, some from each pending entry under different masks, and some from the write one cycle ahead, whose data is arriving on that very edge. Random clock-enable stalls must be able to freeze this state in the middle. The stimulus reaches it by aiming at a pool of only eight words in two burst groups, by issuing reads and writes back to back with random lane masks, and by mixing in bursts and stalls. A behavioural reference then checks the output on every cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic stepEn;     // pipeline advances this edge
    logic rdLoad;     // stage-1 read loads the output register
    logic wrCapture;  // stage-2 write takes dIn into the registry
  } zt_strobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              advLd,
  input  logic              burstIlv,
  input  logic [ADDR_W-1:0] ldAddr,
  input  zt_op_e            ldOp,
  output logic [ADDR_W-1:0] curAddr,
  output zt_op_e            curOp
);

  logic [1:0] baseLow;
  logic [1:0] beatCnt;
  logic [1:0] nextBeat;
  logic       ilvReg;

  assign nextBeat = beatCnt + 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp   <= OP_IDLE;
      curAddr <= '0;
      baseLow <= '0;
      beatCnt <= '0;
      ilvReg  <= 1'b0;
    end else if (stepEn) begin
      if (advLd) begin
        curOp   <= ldOp;
        curAddr <= ldAddr;
        baseLow <= ldAddr[1:0];
        beatCnt <= '0;
        ilvReg  <= burstIlv;
      end else begin
        beatCnt      <= nextBeat;
        curAddr[1:0] <= burstLow(baseLow, nextBeat, ilvReg);
      end
    end
  end

  // R9: a linear advance moves the low bits up by one, modulo 4
  p_lin_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !advLd && !ilvReg) |=>
      (curAddr[1:0] == 2'($past(curAddr[1:0]) + 2'd1)));

  // R10: an interleaved advance always flips address bit 0
  p_ilv_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !advLd && ilvReg) |=> (curAddr[0] != $past(curAddr[0])));

  // R8: an advance keeps the upper address bits and the command type
  p_adv_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !advLd) |=>
      ($stable(curAddr[ADDR_W-1:2]) && $stable(curOp)));

endmodule

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic              advLd,
  input  logic              burstIlv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bwN,
  output zt_strobe_t        strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrMask
);

  logic              stepEn;
  logic              chipSel;
  zt_op_e            ldOp;
  zt_op_e            op1;
  zt_op_e            op2;
  logic [ADDR_W-1:0] addr1;
  logic [ADDR_W-1:0] addr2;
  logic [LANES-1:0]  mask1;
  logic [LANES-1:0]  mask2;

  assign stepEn  = !cenN;
  assign chipSel = !ce1N && ce2 && !ce3N;
  assign ldOp    = !chipSel ? OP_IDLE : (!weN ? OP_WRITE : OP_READ);

  // Stage 1: input register with burst sequencing
  zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .stepEn  (stepEn),
    .advLd   (advLd),
    .burstIlv(burstIlv),
    .ldAddr  (addr),
    .ldOp    (ldOp),
    .curAddr (addr1),
    .curOp   (op1)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask1 <= '0;
      op2   <= OP_IDLE;
      addr2 <= '0;
      mask2 <= '0;
    end else if (stepEn) begin
      mask1 <= ~bwN;
      op2   <= op1;
      addr2 <= addr1;
      mask2 <= mask1;
    end
  end

  always_comb begin
    strb.stepEn    = stepEn;
    strb.rdLoad    = stepEn && (op1 == OP_READ);
    strb.wrCapture = stepEn && (op2 == OP_WRITE);
  end

  assign rdAddr = addr1;
  assign wrAddr = addr2;
  assign wrMask = mask2;

  // R5: a load without full selection yields no access
  p_deselect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && advLd && !chipSel) |=> (op1 == OP_IDLE));

  // R3: a stall freezes both command stages
  p_stall_ctrl_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn) |=> ($stable(op1) && $stable(op2) && $stable(addr2)));

endmodule

// File: rtl/zt_sram_dpath.sv
module zt_sram_dpath
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int PEND_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  zt_strobe_t              strb,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrMask,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] qOut,
  output logic                    qDrv
);

  localparam int WORD_W    = LANES * LANE_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int LAST      = PEND_DEPTH - 1;

  logic [WORD_W-1:0]     memArr [MEM_DEPTH];
  logic [PEND_DEPTH-1:0] pendV;
  logic [ADDR_W-1:0]     pendA [PEND_DEPTH];
  logic [LANES-1:0]      pendM [PEND_DEPTH];
  logic [WORD_W-1:0]     pendD [PEND_DEPTH];
  logic [WORD_W-1:0]     arrWord;
  logic [WORD_W-1:0]     mergedWord;
  logic                  outValid;

  // Pending-write registry: entry 0 newest, entry LAST oldest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendV <= '0;
    end else if (strb.stepEn) begin
      pendV[0] <= strb.wrCapture;
      for (int p = 1; p < PEND_DEPTH; p++) pendV[p] <= pendV[p-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.stepEn) begin
      pendA[0] <= wrAddr;
      pendM[0] <= wrMask;
      pendD[0] <= dIn;
      for (int p = 1; p < PEND_DEPTH; p++) begin
        pendA[p] <= pendA[p-1];
        pendM[p] <= pendM[p-1];
        pendD[p] <= pendD[p-1];
      end
    end
  end

  // Oldest entry retires into the array
  always_ff @(posedge clk) begin
    if (strb.stepEn && pendV[LAST]) begin
      for (int l = 0; l < LANES; l++)
        if (pendM[LAST][l])
          memArr[pendA[LAST]][l*LANE_W +: LANE_W] <= pendD[LAST][l*LANE_W +: LANE_W];
    end
  end

  assign arrWord = memArr[rdAddr];

  // Per-lane coherent merge: array, then registry oldest to newest, then in-flight data
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [LANE_W-1:0] laneVal;
    always_comb begin
      laneVal = arrWord[gl*LANE_W +: LANE_W];
      for (int p = LAST; p >= 0; p--)
        if (pendV[p] && pendM[p][gl] && (pendA[p] == rdAddr))
          laneVal = pendD[p][gl*LANE_W +: LANE_W];
      if (strb.wrCapture && wrMask[gl] && (wrAddr == rdAddr))
        laneVal = dIn[gl*LANE_W +: LANE_W];
    end
    assign mergedWord[gl*LANE_W +: LANE_W] = laneVal;
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else if (strb.stepEn) outValid <= strb.rdLoad;
  end

  always_ff @(posedge clk) begin
    if (strb.rdLoad) qOut <= mergedWord;
  end

  assign qDrv = outValid && !oeN;

  // R6: read data is never on the bus while write data is being taken
  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCapture |-> !outValid);

  // R3: a stall holds the output register
  p_stall_out_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepEn) |=> ($stable(outValid) && $stable(qOut)));

  // R7: a captured write is in the registry on the next edge
  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCapture |=> pendV[0]);

endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int PEND_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cenN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    weN,
  input  logic                    advLd,
  input  logic                    burstIlv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bwN,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] qOut,
  output logic                    qDrv
);

  zt_strobe_t        strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrMask;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cenN    (cenN),
    .ce1N    (ce1N),
    .ce2     (ce2),
    .ce3N    (ce3N),
    .weN     (weN),
    .advLd   (advLd),
    .burstIlv(burstIlv),
    .addr    (addr),
    .bwN     (bwN),
    .strb    (strb),
    .rdAddr  (rdAddr),
    .wrAddr  (wrAddr),
    .wrMask  (wrMask)
  );

  zt_sram_dpath #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .LANE_W    (LANE_W),
    .PEND_DEPTH(PEND_DEPTH)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdAddr(rdAddr),
    .wrAddr(wrAddr),
    .wrMask(wrMask),
    .dIn   (dIn),
    .oeN   (oeN),
    .qOut  (qOut),
    .qDrv  (qDrv)
  );

endmodule

// File: tb/zt_pipe_sram_bench.sv
`timescale 1ns/1ps
module zt_pipe_sram_bench;

  localparam logic [2:0] SEL = 3'b010;  // {ce1N, ce2, ce3N}

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cenN = 1'b0, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic        weN = 1'b1, advLd = 1'b1, burstIlv = 1'b0, oeN = 1'b0;
  logic [9:0]  addr = '0;
  logic [3:0]  bwN = 4'hF;
  logic [35:0] dIn = '0;
  logic [35:0] qOut;
  logic        qDrv;

  int    nCmp = 0, nBad = 0;
  bit    done = 1'b0;
  string curReq = "R11";

  always #2.5 clk = ~clk;

  zt_pipe_sram u_zt_pipe_sram (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .advLd(advLd), .burstIlv(burstIlv), .addr(addr), .bwN(bwN),
    .dIn(dIn), .oeN(oeN), .qOut(qOut), .qDrv(qDrv)
  );

  // ---------------- reference model ----------------
  typedef struct { bit v; bit w; int a; bit [3:0] m; } cmd_t;
  logic [35:0] refMem [int];
  cmd_t h1, h2, c;
  bit   bV, bW, bIlv, expValid, expKnown;
  int   bBase, bCnt, low;
  logic [35:0] expQ, tmpW;

  task automatic chk(string req, bit ok, logic [35:0] act, logic [35:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s t=%0t: got %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      h1.v = 0; h2.v = 0; expValid = 0; bV = 0; bW = 0; bBase = 0; bCnt = 0;
    end else if (!cenN) begin
      if (advLd) begin
        bV = (!ce1N && ce2 && !ce3N); bW = !weN; bBase = int'(addr); bCnt = 0;
        bIlv = burstIlv; c.a = int'(addr);
      end else begin
        bCnt = (bCnt + 1) % 4;
        low  = bIlv ? ((bBase % 4) ^ bCnt) : (((bBase % 4) + bCnt) % 4);
        c.a  = (bBase / 4) * 4 + low;
      end
      c.v = bV; c.w = bW; c.m = ~bwN;
      if (h2.v && h2.w) begin
        tmpW = refMem.exists(h2.a) ? refMem[h2.a] : 36'h0;
        for (int l = 0; l < 4; l++) if (h2.m[l]) tmpW[l*9 +: 9] = dIn[l*9 +: 9];
        refMem[h2.a] = tmpW;
      end
      if (h1.v && !h1.w) begin
        expValid = 1; expKnown = refMem.exists(h1.a);
        if (expKnown) expQ = refMem[h1.a];
      end else expValid = 0;
      h2 = h1; h1 = c;
    end
    #1;
    if (!rstN) chk("R11", qDrv == 1'b0, 36'(qDrv), 36'h0);
    else begin
      chk(curReq, qDrv === (expValid && !oeN), 36'(qDrv), 36'(expValid && !oeN));
      if (qDrv && expValid && expKnown) chk(curReq, qOut === expQ, qOut, expQ);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(bit adv, logic [2:0] ce, bit wr, int a, logic [3:0] bw,
                     bit ilv, bit cen, bit oe);
    @(negedge clk);
    advLd = adv; {ce1N, ce2, ce3N} = ce; weN = !wr; addr = 10'(a); bwN = bw;
    burstIlv = ilv; cenN = cen; oeN = oe; dIn = 36'({$urandom, $urandom});
  endtask

  function automatic int poolAddr();
    return ($urandom % 2) ? int'($urandom % 4) : 1020 + int'($urandom % 4);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 3'b110, 0, 0, 4'hF, 0, 0, 0);
  endtask

  task automatic rndCyc(bit stalls, bit oes);
    logic [2:0] ce = ($urandom % 8 == 0) ? 3'($urandom) : SEL;
    cyc(($urandom % 4) != 0, ce, $urandom % 2, poolAddr(), 4'($urandom),
        $urandom % 2, stalls && ($urandom % 4 == 0), oes && ($urandom % 4 == 0));
  endtask

  initial begin
    // R11: reset state
    idle(4);
    @(negedge clk); rstN = 1'b1;
    // R12: back-to-back full writes to the word pool, then back-to-back reads (R1)
    curReq = "R12";
    for (int i = 0; i < 8; i++) cyc(1, SEL, 1, (i < 4) ? i : 1016 + i, 4'h0, 0, 0, 0);
    curReq = "R1";
    for (int i = 0; i < 8; i++) cyc(1, SEL, 0, (i < 4) ? i : 1016 + i, 4'hF, 0, 0, 0);
    idle(3);
    // R4 / R7: partial masks, read right after write, alternating W/R on one word
    curReq = "R4";
    cyc(1, SEL, 1, 1, 4'b1010, 0, 0, 0);
    cyc(1, SEL, 0, 1, 4'hF, 0, 0, 0);
    cyc(1, SEL, 1, 1, 4'b0101, 0, 0, 0);
    cyc(1, SEL, 1, 1, 4'b1110, 0, 0, 0);
    cyc(1, SEL, 0, 1, 4'hF, 0, 0, 0);
    curReq = "R7";
    for (int i = 0; i < 12; i++) cyc(1, SEL, i % 2 == 0, 2, 4'($urandom), 0, 0, 0);
    idle(3);
    // R5: deselect combinations, write attempts and reads, then read back
    curReq = "R5";
    cyc(1, 3'b110, 1, 3, 4'h0, 0, 0, 0);
    cyc(1, 3'b000, 1, 3, 4'h0, 0, 0, 0);
    cyc(1, 3'b011, 1, 3, 4'h0, 0, 0, 0);
    cyc(1, 3'b000, 0, 3, 4'hF, 0, 0, 0);
    idle(3);
    cyc(1, SEL, 0, 3, 4'hF, 0, 0, 0);
    idle(3);
    // R8 / R9 / R10: bursts in both orders from every start; ce/we toggled on advance
    for (int ilv = 0; ilv < 2; ilv++) begin
      curReq = ilv ? "R10" : "R9";
      for (int s = 0; s < 4; s++) begin
        cyc(1, SEL, 1, 1020 + s, 4'($urandom), ilv, 0, 0);
        for (int b = 0; b < 3; b++) cyc(0, 3'b101, 0, 0, 4'($urandom), !ilv, 0, 0);
        cyc(1, SEL, 0, 1020 + s, 4'hF, ilv, 0, 0);
        for (int b = 0; b < 3; b++) cyc(0, 3'b111, 1, 5, 4'h0, !ilv, 0, 0);
      end
    end
    curReq = "R8";
    for (int i = 0; i < 200; i++) rndCyc(0, 0);
    // R3: stalls in mixed traffic
    curReq = "R3";
    for (int i = 0; i < 400; i++) rndCyc(1, 0);
    // R6: output enable toggling
    curReq = "R6";
    for (int i = 0; i < 300; i++) rndCyc(0, 1);
    // R7 / R2: long random mix
    curReq = "R2";
    for (int i = 0; i < 3000; i++) rndCyc(1, 1);
    // R11: drain, reset mid-run, contents survive
    idle(6);
    curReq = "R11";
    @(negedge clk); rstN = 1'b0;
    idle(3);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1, SEL, 0, (i < 4) ? i : 1016 + i, 4'hF, 0, 0, 0);
    idle(4);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule